// File: doc/BRIEF.md
# Noise-Adaptive Three-Level Link Codec

This block protects a point-to-point on-chip link whose protection strength can be changed at run time. The transmit half sends every data bit on two adjacent wires, so neighbouring wires never switch against each other within a pair. Depending on a two-bit protection level input it can add a parity per row of the data word, or a parity per row and a parity per column. Each parity is also carried on a wire pair. When a parity group is switched off, its wires stay at a constant zero and draw no switching energy.

The receive half checks the wires it gets against the level in force. It returns the word one cycle later with a valid flag when every check passes. When any check fails, it raises a retransmission request instead. The level comes from an external noise monitor that is outside this block. It may change only between words, and the same value governs both halves.

The data word is treated as a grid of ROWS rows by COLS columns. Bit `r*COLS + c` sits in row r and column c. Data bit i is sent on wires 2i and 2i+1. Row parity r is sent on row wires 2r and 2r+1, and column parity c on column wires 2c and 2c+1. Every parity is even, meaning the XOR of its bits.

Top module: `nac_link_codec`

## Requirements
- R1: The level input is decoded as 00 = light, 01 = medium and 10 = strong. The code 11 behaves exactly like 10 on both halves.
- R2: In every level, transmit data wires 2i and 2i+1 both carry data bit i.
- R3: At the light level, all transmit row and column parity wires are 0.
- R4: At the medium level, row wires 2r and 2r+1 both carry the XOR of data bits r*COLS to r*COLS+COLS-1, and all column wires are 0.
- R5: At the strong level, row wires are as in R4, and column wires 2c and 2c+1 both carry the XOR of data bits c, c+COLS, and so on up to c+(ROWS-1)*COLS.
- R6: A word strobed in on a cycle whose checks all pass produces, on the following cycle, `rx_valid`=1, `retx_req`=0 and `rx_data` equal to the even-numbered receive data wires. `rx_valid` and `retx_req` are never high together.
- R7: At any level, a strobed word whose two copies of some data bit differ produces `retx_req`=1 and `rx_valid`=0 on the following cycle.
- R8: At the medium and strong levels, a strobed word fails when a row parity pair disagrees with itself or with the row parity recomputed from the even data wires.
- R9: At the strong level, a strobed word fails on the same column conditions. At the medium level, the column wires have no effect on the result.
- R10: At the light level, the row and column wires have no effect. As a result, flipping both copies of one data bit passes undetected and is delivered as flipped data.
- R11: A cycle without a strobe gives `rx_valid`=0 and `retx_req`=0 on the next cycle, and `rx_data` keeps its value. A failed word also leaves `rx_data` unchanged.
- R12: While `rst_n` is low, and until the first strobe after it, `rx_valid`=0, `retx_req`=0 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level | input | 2 | Protection level shared by both halves |
| tx_data | input | ROWS*COLS | Word to send |
| tx_link_data | output | 2*ROWS*COLS | Duplicated data wires |
| tx_link_row | output | 2*ROWS | Duplicated row parity wires |
| tx_link_col | output | 2*COLS | Duplicated column parity wires |
| rx_strobe | input | 1 | Receive wires carry a word this cycle |
| rx_link_data | input | 2*ROWS*COLS | Received data wires |
| rx_link_row | input | 2*ROWS | Received row parity wires |
| rx_link_col | input | 2*COLS | Received column parity wires |
| rx_data | output | ROWS*COLS | Last word that passed its checks |
| rx_valid | output | 1 | A word passed its checks on the previous cycle |
| retx_req | output | 1 | A word failed its checks on the previous cycle |

## Verification
The bench builds the codec with its default 4 by 8 grid, which gives a 32-bit word and 88 wires in total. At that size, every single wire can be inverted under each of the four level codes. The same applies to flipping both copies of every data bit, so each wire's role under each level is exercised rather than sampled. The encoder is also swept with walking-one words and several dense patterns under all four codes. This covers the even-parity arithmetic for every row and column.

// File: rtl/nac_pkg.sv
package nac_pkg;

    typedef enum logic [1:0] {
        LVL_LIGHT  = 2'b00,
        LVL_MEDIUM = 2'b01,
        LVL_STRONG = 2'b10
    } lvl_e;

    // the spare code 11 folds onto the strongest level
    function automatic lvl_e lvl_of(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_LIGHT;
            2'b01:   return LVL_MEDIUM;
            default: return LVL_STRONG;
        endcase
    endfunction

endpackage

// File: rtl/nac_parity_gen.sv
module nac_parity_gen #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    localparam int W   = ROWS * COLS
) (
    input  logic [W-1:0]    word,
    output logic [ROWS-1:0] row_par,
    output logic [COLS-1:0] col_par
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_par[r] = ^word[r*COLS +: COLS];
    end

    always_comb begin
        col_par = '0;
        for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS; r++) begin
                col_par[c] = col_par[c] ^ word[r*COLS + c];
            end
        end
    end

endmodule

// File: rtl/nac_encoder.sv
module nac_encoder
    import nac_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    localparam int W   = ROWS * COLS
) (
    input  logic [1:0]        level,
    input  logic [W-1:0]      data,
    output logic [2*W-1:0]    wire_data,
    output logic [2*ROWS-1:0] wire_row,
    output logic [2*COLS-1:0] wire_col
);

    lvl_e            lvl;
    logic            row_on;
    logic            col_on;
    logic [ROWS-1:0] row_par;
    logic [COLS-1:0] col_par;

    assign lvl    = lvl_of(level);
    assign row_on = (lvl != LVL_LIGHT);
    assign col_on = (lvl == LVL_STRONG);

    nac_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_par (
        .word    (data),
        .row_par (row_par),
        .col_par (col_par)
    );

    for (genvar i = 0; i < W; i++) begin : g_dup_data
        assign wire_data[2*i +: 2] = {2{data[i]}};
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_dup_row
        assign wire_row[2*r +: 2] = {2{row_par[r] & row_on}};
    end

    for (genvar c = 0; c < COLS; c++) begin : g_dup_col
        assign wire_col[2*c +: 2] = {2{col_par[c] & col_on}};
    end

endmodule

// File: rtl/nac_decoder.sv
module nac_decoder
    import nac_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    localparam int W   = ROWS * COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        level,
    input  logic              strobe,
    input  logic [2*W-1:0]    wire_data,
    input  logic [2*ROWS-1:0] wire_row,
    input  logic [2*COLS-1:0] wire_col,
    output logic [W-1:0]      data,
    output logic              valid,
    output logic              retx
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         valid;
        logic         retx;
    } dec_st_t;

    dec_st_t st_d, st_q;

    logic [W-1:0]    copy_a, copy_b;
    logic [ROWS-1:0] row_a, row_b, row_calc;
    logic [COLS-1:0] col_a, col_b, col_calc;
    logic            data_bad, row_bad, col_bad, word_bad;
    lvl_e            lvl;

    for (genvar i = 0; i < W; i++) begin : g_split_data
        assign copy_a[i] = wire_data[2*i];
        assign copy_b[i] = wire_data[2*i+1];
    end
    for (genvar r = 0; r < ROWS; r++) begin : g_split_row
        assign row_a[r] = wire_row[2*r];
        assign row_b[r] = wire_row[2*r+1];
    end
    for (genvar c = 0; c < COLS; c++) begin : g_split_col
        assign col_a[c] = wire_col[2*c];
        assign col_b[c] = wire_col[2*c+1];
    end

    nac_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_par (
        .word    (copy_a),
        .row_par (row_calc),
        .col_par (col_calc)
    );

    assign lvl      = lvl_of(level);
    assign data_bad = |(copy_a ^ copy_b);
    assign row_bad  = |(row_a ^ row_b) | |(row_a ^ row_calc);
    assign col_bad  = |(col_a ^ col_b) | |(col_a ^ col_calc);
    assign word_bad = data_bad
                    | ((lvl != LVL_LIGHT)  & row_bad)
                    | ((lvl == LVL_STRONG) & col_bad);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.retx  = 1'b0;
        if (strobe) begin
            if (word_bad) begin
                st_d.retx  = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.data  = copy_a;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data  = st_q.data;
    assign valid = st_q.valid;
    assign retx  = st_q.retx;

endmodule

// File: rtl/nac_link_codec.sv
module nac_link_codec #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    localparam int W   = ROWS * COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        level,
    input  logic [W-1:0]      tx_data,
    output logic [2*W-1:0]    tx_link_data,
    output logic [2*ROWS-1:0] tx_link_row,
    output logic [2*COLS-1:0] tx_link_col,
    input  logic              rx_strobe,
    input  logic [2*W-1:0]    rx_link_data,
    input  logic [2*ROWS-1:0] rx_link_row,
    input  logic [2*COLS-1:0] rx_link_col,
    output logic [W-1:0]      rx_data,
    output logic              rx_valid,
    output logic              retx_req
);

    nac_encoder #(.ROWS(ROWS), .COLS(COLS)) u_enc (
        .level     (level),
        .data      (tx_data),
        .wire_data (tx_link_data),
        .wire_row  (tx_link_row),
        .wire_col  (tx_link_col)
    );

    nac_decoder #(.ROWS(ROWS), .COLS(COLS)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (level),
        .strobe    (rx_strobe),
        .wire_data (rx_link_data),
        .wire_row  (rx_link_row),
        .wire_col  (rx_link_col),
        .data      (rx_data),
        .valid     (rx_valid),
        .retx      (retx_req)
    );

endmodule

// File: rtl/nac_link_codec_chk.sv
module nac_link_codec_chk #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    localparam int W   = ROWS * COLS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        level,
    input logic [2*W-1:0]    tx_link_data,
    input logic [2*ROWS-1:0] tx_link_row,
    input logic [2*COLS-1:0] tx_link_col,
    input logic              rx_strobe,
    input logic [2*W-1:0]    rx_link_data,
    input logic [W-1:0]      rx_data,
    input logic              rx_valid,
    input logic              retx_req
);

    logic         tx_pairs_ok, row_pairs_ok, rx_pairs_ok;
    logic [W-1:0] rx_even;

    always_comb begin
        tx_pairs_ok  = 1'b1;
        rx_pairs_ok  = 1'b1;
        row_pairs_ok = 1'b1;
        rx_even      = '0;
        for (int i = 0; i < W; i++) begin
            if (tx_link_data[2*i] != tx_link_data[2*i+1]) tx_pairs_ok = 1'b0;
            if (rx_link_data[2*i] != rx_link_data[2*i+1]) rx_pairs_ok = 1'b0;
            rx_even[i] = rx_link_data[2*i];
        end
        for (int r = 0; r < ROWS; r++) begin
            if (tx_link_row[2*r] != tx_link_row[2*r+1]) row_pairs_ok = 1'b0;
        end
    end

    AST_TX_DATA_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pairs_ok); // R2
    AST_LIGHT_PARITY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 2'b00) |-> (tx_link_row == '0 && tx_link_col == '0)); // R3
    AST_MEDIUM_COL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 2'b01) |-> (tx_link_col == '0)); // R4
    AST_ROW_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        row_pairs_ok); // R5
    AST_VALID_RETX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && retx_req)); // R6
    AST_COPY_MISMATCH_RETX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !rx_pairs_ok) |=> (retx_req && !rx_valid)); // R7
    AST_LIGHT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && rx_pairs_ok && level == 2'b00)
        |=> (rx_valid && rx_data == $past(rx_even))); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |=> (!rx_valid && !retx_req)); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |=> $stable(rx_data)); // R11

endmodule

bind nac_link_codec nac_link_codec_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .level        (level),
    .tx_link_data (tx_link_data),
    .tx_link_row  (tx_link_row),
    .tx_link_col  (tx_link_col),
    .rx_strobe    (rx_strobe),
    .rx_link_data (rx_link_data),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .retx_req     (retx_req)
);

// File: tb/nac_link_codec_test.sv
module nac_link_codec_test;

    localparam int R = 4;
    localparam int C = 8;
    localparam int W = R * C;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     level = 2'b00;
    logic [W-1:0]   tx_data = '0;
    logic [2*W-1:0] tx_link_data;
    logic [2*R-1:0] tx_link_row;
    logic [2*C-1:0] tx_link_col;
    logic           rx_strobe = 1'b0;
    logic [2*W-1:0] rx_link_data = '0;
    logic [2*R-1:0] rx_link_row = '0;
    logic [2*C-1:0] rx_link_col = '0;
    logic [W-1:0]   rx_data;
    logic           rx_valid;
    logic           retx_req;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] last_good = '0;

    always #10 clk = ~clk;

    nac_link_codec #(.ROWS(R), .COLS(C)) uut (
        .clk(clk), .rst_n(rst_n), .level(level), .tx_data(tx_data),
        .tx_link_data(tx_link_data), .tx_link_row(tx_link_row), .tx_link_col(tx_link_col),
        .rx_strobe(rx_strobe), .rx_link_data(rx_link_data), .rx_link_row(rx_link_row),
        .rx_link_col(rx_link_col), .rx_data(rx_data), .rx_valid(rx_valid), .retx_req(retx_req)
    );

    task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [R-1:0] rpar(input logic [W-1:0] d);
        logic [R-1:0] p = '0;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) p[r] = p[r] ^ d[r*C + c];
        return p;
    endfunction

    function automatic logic [C-1:0] cpar(input logic [W-1:0] d);
        logic [C-1:0] p = '0;
        for (int c = 0; c < C; c++)
            for (int r = 0; r < R; r++) p[c] = p[c] ^ d[r*C + c];
        return p;
    endfunction

    // strength: 0 light, 1 medium, 2 strong (code 3 counts as 2)
    function automatic int strength(input logic [1:0] m);
        return (m == 2'b00) ? 0 : (m == 2'b01) ? 1 : 2;
    endfunction

    task automatic send(input logic [1:0] m, input logic [W-1:0] d,
                        input logic [2*W-1:0] fd, input logic [2*R-1:0] fr,
                        input logic [2*C-1:0] fc, input string req);
        logic [2*W-1:0] ed;
        logic [2*R-1:0] er;
        logic [2*C-1:0] ec;
        logic [R-1:0]   rp;
        logic [C-1:0]   cp;
        logic [W-1:0]   a, b;
        logic [R-1:0]   ra, rb;
        logic [C-1:0]   ca, cb;
        logic           pass;
        string          enc_req;
        int             s;
        s  = strength(m);
        rp = rpar(d);
        cp = cpar(d);
        for (int i = 0; i < W; i++) begin ed[2*i] = d[i]; ed[2*i+1] = d[i]; end
        for (int r = 0; r < R; r++) begin er[2*r] = (s >= 1) & rp[r]; er[2*r+1] = (s >= 1) & rp[r]; end
        for (int c = 0; c < C; c++) begin ec[2*c] = (s == 2) & cp[c]; ec[2*c+1] = (s == 2) & cp[c]; end
        @(negedge clk);
        level        = m;
        tx_data      = d;
        rx_strobe    = 1'b1;
        rx_link_data = ed ^ fd;
        rx_link_row  = er ^ fr;
        rx_link_col  = ec ^ fc;
        #1;
        enc_req = (m == 2'b11) ? "R1" : (s == 0) ? "R3" : (s == 1) ? "R4" : "R5";
        chk(tx_link_data == ed, "R2", tx_link_data, ed);
        chk({tx_link_row, tx_link_col} == {er, ec}, enc_req, {tx_link_row, tx_link_col}, {er, ec});
        // expected verdict from the received wires
        for (int i = 0; i < W; i++) begin a[i] = rx_link_data[2*i]; b[i] = rx_link_data[2*i+1]; end
        for (int r = 0; r < R; r++) begin ra[r] = rx_link_row[2*r]; rb[r] = rx_link_row[2*r+1]; end
        for (int c = 0; c < C; c++) begin ca[c] = rx_link_col[2*c]; cb[c] = rx_link_col[2*c+1]; end
        pass = (a == b);
        if (s >= 1) pass = pass && (ra == rb) && (ra == rpar(a));
        if (s == 2) pass = pass && (ca == cb) && (ca == cpar(a));
        @(negedge clk);
        rx_strobe = 1'b0;
        if (pass) last_good = a;
        chk(rx_valid == pass && retx_req == !pass, req, {rx_valid, retx_req}, {pass, !pass});
        chk(rx_data == last_good, pass ? "R6" : "R11", rx_data, last_good);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [W-1:0] pat;
        repeat (3) @(negedge clk);
        chk(!rx_valid && !retx_req && rx_data == '0, "R12", {rx_valid, retx_req, rx_data}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_valid && !retx_req && rx_data == '0, "R12", {rx_valid, retx_req, rx_data}, '0);

        // clean words, all level codes
        for (int m = 0; m < 4; m++) begin
            send(m[1:0], '0, '0, '0, '0, "R6");
            send(m[1:0], '1, '0, '0, '0, "R6");
            send(m[1:0], 32'hA5C3_0F96, '0, '0, '0, "R6");
            for (int i = 0; i < W; i++) send(m[1:0], W'(1) << i, '0, '0, '0, "R6");
        end

        pat = 32'h3C96_E15A;
        for (int m = 0; m < 4; m++) begin
            int s;
            s = strength(m[1:0]);
            // single data wire inverted
            for (int k = 0; k < 2*W; k++)
                send(m[1:0], pat, (2*W)'(1) << k, '0, '0, "R7");
            // both copies of one data bit inverted
            for (int i = 0; i < W; i++)
                send(m[1:0], pat, (2*W)'(3) << (2*i), '0, '0, (s == 0) ? "R10" : "R8");
            // single row wire inverted
            for (int k = 0; k < 2*R; k++)
                send(m[1:0], pat, '0, (2*R)'(1) << k, '0, (s == 0) ? "R10" : "R8");
            // single column wire inverted
            for (int k = 0; k < 2*C; k++)
                send(m[1:0], pat, '0, '0, (2*C)'(1) << k, (s == 0) ? "R10" : "R9");
            // whole parity pairs inverted together
            send(m[1:0], pat, '0, '1, '0, (s == 0) ? "R10" : "R8");
            send(m[1:0], pat, '0, '0, '1, (s == 2) ? "R9" : "R10");
        end

        // idle cycles with noisy wires
        send(2'b10, 32'h1234_5678, '0, '0, '0, "R6");
        @(negedge clk);
        rx_link_data = '1 ^ {W{2'b01}};
        rx_link_row  = '1;
        rx_link_col  = '1;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk(!rx_valid && !retx_req, "R11", {rx_valid, retx_req}, 2'b00);
            chk(rx_data == 32'h1234_5678, "R11", rx_data, 32'h1234_5678);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule